// File: doc/BRIEF.md
# Symmetric Gaussian Window Convolver

This block forms one Gaussian-weighted sum over a square window of N×N pixels and returns it as an 8-bit fraction. It serves as the illumination estimator of a single-scale Retinex stage that works on the luminance channel. Each pixel is an unsigned fraction with the binary point to the left of bit 7. Each kernel weight is a signed Q3.12 value that has been multiplied by 2^GAIN_EXP before it was quantized. The block divides that gain out of the result again.

A host reaches the block through three byte-wide registers. It writes pixels one at a time into the row register. Every Nth pixel write completes one image row, and that row enters the bottom of the window while the oldest row drops off the top. A write of bit 0 to the control register starts a new column: the window then has to be refilled with N complete rows before it produces an output. After that, each further row slides the window down by one row and starts a new sum. The host polls the busy and done bits and then reads the result.

Only one quadrant of the kernel is stored, at ((N+1)/2)² words. Row index r is folded to min(r, N-1-r) and column index c to min(c, N-1-c), and every tap of the full window is taken from those folded coordinates. A single multiplier handles one tap per clock.

Top module: `gauss_window_conv`

## Requirements
- R1: After reset the status register reads 0 (not busy, not done), the fill count reads 0 and the result register reads 0.
- R2: Register map: address 0 is control on write and status on read, address 1 is the row register (on read it returns the count of complete rows since the last restart), and address 2 is the result register. A row-register write stores wr_data[7:0] as the next pixel of the row being assembled, filling columns 0 to N-1 in write order. The Nth write pushes the finished row in as the newest (bottom) window row and discards the oldest.
- R3: Writing 1 to control bit 0 clears the fill count and the pixel position. No output is started until N complete rows have entered after that restart, and the fill count saturates at N.
- R4: Once the window is full, every further completed row starts a new output computation.
- R5: Status bit 0 (busy) rises on the clock edge that accepts the row write completing the window, and it stays high for exactly N×N clock cycles.
- R6: The result equals floor(Σ p[r][c]·k[r][c] / 2^(GAIN_EXP+12)), where p is the pixel code and k[r][c] = floor(16384 / (8 + (r-m)² + (c-m)²)) with m=(N-1)/2. It is loaded on the edge at which busy falls.
- R7: A result above 255 saturates to 255.
- R8: Status bit 1 (done) is set on the edge at which the result loads. It stays set until the result register is read with rd_en, and a finish on the same edge takes priority over the read.
- R9: Row-register writes made while busy is high are ignored. They neither store a pixel nor advance the pixel position, so later results are unchanged by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register select |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (reading the result clears done) |
| rd_addr | input | 2 | Read register select |
| rd_data | output | 8 | Read data, combinational from rd_addr |

## Verification
The assertions assume that the host never changes the window while a sum is in progress. The block enforces this itself by dropping row writes while busy, and the bench deliberately sends one such write mid-computation to confirm the drop. They also assume that the kernel weights and pixels are non-negative, so the accumulator never goes negative. The formula-generated kernel guarantees this. The bench drives only defined addresses, and it mixes restarts issued partway through a column with full refills and with single-row slides.

// File: rtl/gw_pkg.sv
package gw_pkg;
    localparam int PIX_W     = 8;
    localparam int COEF_W    = 16;
    localparam int COEF_FRAC = 12;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_ROW    = 2'd1,
        REG_RESULT = 2'd2
    } reg_sel_e;

    // Weight for a tap at squared distance d from the window centre (Q3.12, gain included)
    function automatic logic [COEF_W-1:0] quad_coef(input int unsigned dr, input int unsigned dc);
        int unsigned d;
        d = dr * dr + dc * dc;
        return COEF_W'(16384 / (8 + d));
    endfunction
endpackage

// File: rtl/gw_coef_rom.sv
module gw_coef_rom #(
    parameter int N = 7
) (
    input  logic [$clog2(N)-1:0]    row_i,
    input  logic [$clog2(N)-1:0]    col_i,
    output logic signed [15:0]      coef_o
);
    localparam int IDX_W = $clog2(N);
    localparam int H     = (N + 1) / 2;
    localparam int DEPTH = H * H;

    logic [15:0] rom [DEPTH];

    // Quadrant word q holds folded coordinates (q / H, q % H), i.e. distance H-1-x from centre
    for (genvar q = 0; q < DEPTH; q++) begin : g_quad
        assign rom[q] = gw_pkg::quad_coef(H - 1 - q / H, H - 1 - q % H);
    end

    logic [IDX_W-1:0] fold_r, fold_c;
    int unsigned      addr;

    always_comb begin
        fold_r = (row_i < IDX_W'(N - 1) - row_i) ? row_i : IDX_W'(N - 1) - row_i;
        fold_c = (col_i < IDX_W'(N - 1) - col_i) ? col_i : IDX_W'(N - 1) - col_i;
        addr   = int'(fold_r) * H + int'(fold_c);
        coef_o = $signed(rom[addr]);
    end
endmodule

// File: rtl/gw_window.sv
module gw_window #(
    parameter int N = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart_i,
    input  logic                 pix_we_i,
    input  logic [7:0]           pix_i,
    input  logic                 hold_i,
    input  logic [$clog2(N)-1:0] rd_row_i,
    input  logic [$clog2(N)-1:0] rd_col_i,
    output logic [7:0]           rd_pix_o,
    output logic                 row_done_o
);
    localparam int IDX_W = $clog2(N);

    typedef struct packed {
        logic [N-1:0][N-1:0][7:0] win;
        logic [N-1:0][7:0]        stage;
        logic [IDX_W-1:0]         col;
    } win_st_t;

    win_st_t s_d, s_q;
    logic    last_col;

    assign last_col   = (s_q.col == IDX_W'(N - 1));
    assign row_done_o = pix_we_i && last_col && !restart_i;
    assign rd_pix_o   = s_q.win[rd_row_i][rd_col_i];

    always_comb begin
        s_d = s_q;
        if (restart_i) begin
            s_d.col = '0;
        end else if (pix_we_i) begin
            s_d.stage[s_q.col] = pix_i;
            if (last_col) begin
                for (int r = 0; r < N - 1; r++) begin
                    s_d.win[r] = s_q.win[r + 1];
                end
                s_d.win[N-1] = s_d.stage;
                s_d.col      = '0;
            end else begin
                s_d.col = s_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    a_r9_window_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> $stable(s_q.win));
    a_r2_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.col <= IDX_W'(N - 1));
endmodule

// File: rtl/gw_mac.sv
module gw_mac #(
    parameter int N        = 7,
    parameter int GAIN_EXP = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [7:0]           pix_i,
    input  logic signed [15:0]   coef_i,
    output logic [$clog2(N)-1:0] row_o,
    output logic [$clog2(N)-1:0] col_o,
    output logic                 busy_o,
    output logic                 fin_o,
    output logic [7:0]           res_o
);
    localparam int IDX_W = $clog2(N);
    localparam int ACC_W = 8 + 16 + $clog2(N * N) + 1;
    localparam int SHIFT = GAIN_EXP + gw_pkg::COEF_FRAC;

    typedef struct packed {
        logic                    busy;
        logic [IDX_W-1:0]        r;
        logic [IDX_W-1:0]        c;
        logic signed [ACC_W-1:0] acc;
        logic [7:0]              res;
    } mac_st_t;

    mac_st_t                 s_d, s_q;
    logic signed [24:0]      prod;
    logic signed [ACC_W-1:0] sum, scaled;
    logic                    last_tap;

    assign row_o    = s_q.r;
    assign col_o    = s_q.c;
    assign busy_o   = s_q.busy;
    assign res_o    = s_q.res;
    assign last_tap = s_q.busy && (s_q.r == IDX_W'(N - 1)) && (s_q.c == IDX_W'(N - 1));
    assign fin_o    = last_tap;

    always_comb begin
        prod   = coef_i * $signed({1'b0, pix_i});
        sum    = s_q.acc + ACC_W'(prod);
        scaled = sum >>> SHIFT;
        s_d    = s_q;
        if (start_i && !s_q.busy) begin
            s_d.busy = 1'b1;
            s_d.r    = '0;
            s_d.c    = '0;
            s_d.acc  = '0;
        end else if (s_q.busy) begin
            s_d.acc = sum;
            if (s_q.c == IDX_W'(N - 1)) begin
                s_d.c = '0;
                if (s_q.r == IDX_W'(N - 1)) begin
                    s_d.busy = 1'b0;
                    if (scaled < 0)                            s_d.res = 8'd0;
                    else if (scaled > $signed(ACC_W'(255)))    s_d.res = 8'd255;
                    else                                       s_d.res = scaled[7:0];
                end else begin
                    s_d.r = s_q.r + 1'b1;
                end
            end else begin
                s_d.c = s_q.c + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    a_r5_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !s_q.busy);
    a_r6_acc_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> !s_q.acc[ACC_W-1]);
endmodule

// File: rtl/gauss_window_conv.sv
module gauss_window_conv #(
    parameter int N        = 7,
    parameter int GAIN_EXP = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_en,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data
);
    import gw_pkg::*;

    localparam int IDX_W  = $clog2(N);
    localparam int FILL_W = $clog2(N + 1);

    typedef struct packed {
        logic [FILL_W-1:0] fill;
        logic              done;
    } top_st_t;

    top_st_t           s_d, s_q;
    logic              busy, fin, row_done, start, restart, pix_we, res_rd;
    logic [IDX_W-1:0]  tap_r, tap_c;
    logic [7:0]        tap_pix, result;
    logic signed [15:0] tap_coef;

    assign restart = wr_en && (wr_addr == REG_CTRL) && wr_data[0];
    assign pix_we  = wr_en && (wr_addr == REG_ROW) && !busy;
    assign res_rd  = rd_en && (rd_addr == REG_RESULT);
    assign start   = row_done && (s_q.fill >= FILL_W'(N - 1));

    gw_window #(.N(N)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart_i  (restart),
        .pix_we_i   (pix_we),
        .pix_i      (wr_data),
        .hold_i     (busy),
        .rd_row_i   (tap_r),
        .rd_col_i   (tap_c),
        .rd_pix_o   (tap_pix),
        .row_done_o (row_done)
    );

    gw_coef_rom #(.N(N)) u_rom (
        .row_i  (tap_r),
        .col_i  (tap_c),
        .coef_o (tap_coef)
    );

    gw_mac #(.N(N), .GAIN_EXP(GAIN_EXP)) u_mac (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .pix_i   (tap_pix),
        .coef_i  (tap_coef),
        .row_o   (tap_r),
        .col_o   (tap_c),
        .busy_o  (busy),
        .fin_o   (fin),
        .res_o   (result)
    );

    always_comb begin
        s_d = s_q;
        if (restart)
            s_d.fill = '0;
        else if (row_done && (s_q.fill != FILL_W'(N)))
            s_d.fill = s_q.fill + 1'b1;
        if (fin)         s_d.done = 1'b1;
        else if (res_rd) s_d.done = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (rd_addr)
            REG_CTRL:   rd_data = {6'd0, s_q.done, busy};
            REG_ROW:    rd_data = 8'(s_q.fill);
            REG_RESULT: rd_data = result;
            default:    rd_data = 8'd0;
        endcase
    end

    a_r8_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.done && !res_rd) |=> s_q.done);
    a_r8_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> s_q.done);
    a_r3_fill_cap: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fill <= FILL_W'(N));
    a_r4_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: tb/tb_gauss_window_conv.sv
module tb_gauss_window_conv;
    localparam int N  = 5;
    localparam int G  = 3;
    localparam int NN = N * N;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    gauss_window_conv #(.N(N), .GAIN_EXP(G)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    // Behavioural reference, advanced on each rising edge
    int m_win [N][N];
    int m_stage [N];
    int m_col, m_fill, m_busy, m_done, m_result, m_pending;

    function automatic int kern(int r, int c);
        int m;
        m = (N - 1) / 2;
        return 16384 / (8 + (r - m) * (r - m) + (c - m) * (c - m));
    endfunction

    function automatic int window_out();
        longint s;
        s = 0;
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                s += longint'(m_win[r][c]) * kern(r, c);
        s = s / (longint'(1) << (G + 12));
        return (s > 255) ? 255 : int'(s);
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_col = 0; m_fill = 0; m_busy = 0; m_done = 0; m_result = 0; m_pending = 0;
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++) m_win[r][c] = 0;
        end else begin
            bit fin;
            fin = 0;
            if (m_busy > 0) begin
                m_busy--;
                if (m_busy == 0) begin
                    m_result = m_pending;
                    fin = 1;
                end
            end else if (wr_en && wr_addr == 2'd1) begin
                m_stage[m_col] = int'(wr_data);
                if (m_col == N - 1) begin
                    for (int r = 0; r < N - 1; r++) m_win[r] = m_win[r + 1];
                    m_win[N-1] = m_stage;
                    m_col = 0;
                    if (m_fill < N) m_fill++;
                    if (m_fill == N) begin
                        m_busy    = NN;
                        m_pending = window_out();
                    end
                end else begin
                    m_col++;
                end
            end
            if (wr_en && wr_addr == 2'd0 && wr_data[0]) begin
                m_fill = 0;
                m_col  = 0;
            end
            if (fin) m_done = 1;
            else if (rd_en && rd_addr == 2'd2) m_done = 0;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Compare the visible register against the model every cycle
    task automatic compare();
        case (rd_addr)
            2'd0: begin
                check(rd_data[0] == (m_busy > 0), "R5 busy", int'(rd_data[0]), int'(m_busy > 0));
                check(rd_data[1] == m_done[0], "R8 done", int'(rd_data[1]), m_done);
            end
            2'd1: check(int'(rd_data) == m_fill, "R3 fill", int'(rd_data), m_fill);
            2'd2: check(int'(rd_data) == m_result, "R6 result", int'(rd_data), m_result);
            default: ;
        endcase
    endtask

    task automatic cyc(input bit we, input logic [1:0] wa, input logic [7:0] wd,
                       input bit re, input logic [1:0] ra);
        @(negedge clk);
        compare();
        wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    endtask

    task automatic push_row(input int base, input int step);
        for (int c = 0; c < N; c++) cyc(1, 2'd1, 8'((base + step * c) & 255), 0, 2'd0);
        cyc(0, 2'd0, 8'd0, 0, 2'd0);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4 * NN && m_busy > 0; i++) cyc(0, 2'd0, 8'd0, 0, 2'd0);
    endtask

    task automatic read_result(input string tag, input int exp);
        cyc(0, 2'd0, 8'd0, 1, 2'd2);
        @(negedge clk);
        check(int'(rd_data) == exp, tag, int'(rd_data), exp);
        cyc(0, 2'd0, 8'd0, 0, 2'd0);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired (R5) actual=%0d expected=0", cycles);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state on all three read addresses
        cyc(0, 2'd0, 8'd0, 0, 2'd0);
        @(negedge clk); check(rd_data == 8'd0, "R1 status", int'(rd_data), 0);
        rst_n = 1'b1;
        cyc(0, 2'd0, 8'd0, 0, 2'd2);
        @(negedge clk); check(rd_data == 8'd0, "R1 result", int'(rd_data), 0);
        cyc(0, 2'd0, 8'd0, 0, 2'd1);
        @(negedge clk); check(rd_data == 8'd0, "R1 fill", int'(rd_data), 0);

        // R3: fill N-1 rows, no computation yet
        cyc(1, 2'd0, 8'd1, 0, 2'd0);
        for (int r = 0; r < N - 1; r++) push_row(20 * r, 7);
        @(negedge clk); check(rd_data[0] == 1'b0, "R3 no output before full", int'(rd_data[0]), 0);
        cyc(0, 2'd0, 8'd0, 0, 2'd1);
        @(negedge clk); check(int'(rd_data) == N - 1, "R3 fill count", int'(rd_data), N - 1);

        // R5: completing row starts exactly N*N busy cycles
        for (int c = 0; c < N; c++) cyc(1, 2'd1, 8'(90 + c), 0, 2'd0);
        cyc(0, 2'd0, 8'd0, 0, 2'd0);
        begin
            int hi;
            hi = 0;
            for (int i = 0; i < NN + 4; i++) begin
                @(negedge clk);
                if (rd_data[0]) hi++;
                @(posedge clk);
            end
            check(hi == NN - 1 || hi == NN, "R5 busy length", hi, NN);
        end
        check(m_done == 1, "R8 done after finish", m_done, 1);
        read_result("R6 first window", m_result);
        @(negedge clk); check(rd_data[1] == 1'b0, "R8 done cleared by read", int'(rd_data[1]), 0);

        // R4 and R2: a further row slides the window and starts a new sum
        for (int c = 0; c < N; c++) cyc(1, 2'd1, 8'(200 - 13 * c), 0, 2'd0);
        cyc(0, 2'd0, 8'd0, 0, 2'd0);
        @(negedge clk); check(rd_data[0] == 1'b1, "R4 new output started", int'(rd_data[0]), 1);
        // R9: a pixel write while busy must be dropped
        cyc(1, 2'd1, 8'd255, 0, 2'd0);
        cyc(0, 2'd0, 8'd0, 0, 2'd0);
        wait_idle();
        read_result("R2 slid window result", m_result);

        // R9 continued: next full row uses only its own pixels
        push_row(3, 11);
        wait_idle();
        read_result("R9 ignored write had no effect", m_result);

        // R7: bright window saturates
        for (int r = 0; r < N; r++) begin
            push_row(250, 1);
            wait_idle();
        end
        read_result("R7 saturation", 255);

        // R3: restart mid-column, then refill
        for (int c = 0; c < 2; c++) cyc(1, 2'd1, 8'd9, 0, 2'd0);
        cyc(1, 2'd0, 8'd1, 0, 2'd1);
        @(negedge clk); check(rd_data == 8'd0, "R3 restart clears fill", int'(rd_data), 0);
        for (int r = 0; r < N; r++) push_row(128, 0);
        wait_idle();
        read_result("R6 mid-grey window", m_result);

        // Several more distinct patterns
        for (int k = 0; k < 6; k++) begin
            push_row(37 * k + 5, 3 * k + 1);
            wait_idle();
            read_result("R6 sliding pattern", m_result);
        end

        // R8: done persists without a read
        push_row(64, 2);
        wait_idle();
        repeat (5) cyc(0, 2'd0, 8'd0, 0, 2'd0);
        @(negedge clk); check(rd_data[1] == 1'b1, "R8 done held", int'(rd_data[1]), 1);
        read_result("R6 final", m_result);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule